// File: doc/BRIEF.md
# Flash Write Protection Controller

This block sits between a CPU write port and a nonvolatile memory array and rules on every memory request. After reset, writes to program memory, data memory and the option-byte area are refused. Software opens them through two key registers: one for program memory, and one for data memory and the option bytes. Each key register takes two byte writes in a fixed order. A wrong byte jams that key register until the next reset. Writing a lock register closes the memory again at once.

A second tier protects a boot-code area at the bottom of program memory. Its size comes from an option-byte input, counted in 512-byte pages. The keys never open it. A read-out protection input makes the block refuse all program and data memory traffic that arrives while the debug path is active. Software may try to change that protection state through a control register. Any such attempt produces a one-cycle mass-erase command.

Each key register runs a four-state machine. KS_LOCKED moves to KS_HALF on the correct first byte and to KS_JAMMED on any other byte. KS_HALF moves to KS_OPEN on the correct second byte, to KS_JAMMED on any other byte, and back to KS_LOCKED on a lock write. KS_OPEN returns to KS_LOCKED on a lock write. KS_JAMMED is left only by reset. The verdict machine goes to AV_GRANT or AV_DENY on each request and to AV_IDLE when there is none. The erase machine goes from ER_IDLE to ER_FIRE on a change attempt and returns to ER_IDLE on the next cycle that has no such attempt.

Top module: `fwp_ctrl`

## Requirements
- R1: After reset, grant, deny, wr_error and erase_all are 0. Reads are granted, and writes to program memory (0x8000–0xFFFF), data memory (0x4000–0x43FF) and option bytes (0x4800–0x487F) are denied.
- R2: Writing 0x56 and then 0xAE to register 0 (the program key) opens program memory, so writes there that fall outside the boot area are granted.
- R3: Writing 0xAE and then 0x56 to register 1 (the data key) opens data memory and the option bytes for writes.
- R4: Writing any other byte to a key register, or writing the right bytes in the wrong order, jams that key register until reset. Later correct sequences then do not open its memory.
- R5: A write to register 2 with bit 0 set closes program memory, and with bit 1 set closes data memory and the option bytes. No key is needed, and the change applies to requests from the next cycle on.
- R6: A program-memory write whose offset from 0x8000, divided by 512, is less than opt_boot_pages is always denied. A page count of 0 means there is no boot area.
- R7: While opt_rdprot and dbg_mode are both 1, reads and writes to program and data memory are denied. Option bytes and other addresses are not affected by this rule.
- R8: A write to register 3 whose bit 0 differs from opt_rdprot raises erase_all for exactly the following cycle. A write equal to opt_rdprot does not raise it.
- R9: For every request, exactly one of grant or deny is high in the following cycle, and neither is high when there was no request. Addresses outside the three protected areas are granted.
- R10: A denied write sets wr_error, which stays at 1 until reset. Denied reads leave it unchanged.
- R11: A request is judged against the lock state that held before any register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_addr | input | 2 | Register select: 0 program key, 1 data key, 2 lock, 3 read-out control |
| reg_wdata | input | 8 | Register write data |
| mem_req | input | 1 | Memory request valid |
| mem_wr | input | 1 | 1 = write request, 0 = read request |
| mem_addr | input | 16 | Request byte address |
| dbg_mode | input | 1 | Request comes from the debug/in-circuit programming path |
| opt_boot_pages | input | 8 | Boot area size in 512-byte pages |
| opt_rdprot | input | 1 | Current read-out protection state |
| grant | output | 1 | Previous-cycle request allowed |
| deny | output | 1 | Previous-cycle request refused |
| wr_error | output | 1 | Sticky denied-write flag |
| erase_all | output | 1 | Mass-erase command pulse |

## Verification
Two pairs of functions can act in the same cycle. A key or lock register write can coincide with a memory request, and a read-out control write can coincide with a denied debug write. The bench provokes the first pair directly: it places the second key byte beside a data write, and a lock write beside a program write. It expects the verdict from the earlier lock state, as R11 requires. Random traffic then mixes register writes and requests in the same cycles. Each verdict is compared with a bench model that applies the register effects only after it has judged the request.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
    typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN, KS_JAMMED} key_state_e;
    typedef enum logic [1:0] {AV_IDLE, AV_GRANT, AV_DENY} verdict_e;
    typedef enum logic {ER_IDLE, ER_FIRE} erase_state_e;
    typedef enum logic [1:0] {RG_NONE, RG_PROG, RG_DATA, RG_OPT} region_e;

    localparam logic [1:0] REG_PKEY = 2'd0;
    localparam logic [1:0] REG_DKEY = 2'd1;
    localparam logic [1:0] REG_LOCK = 2'd2;
    localparam logic [1:0] REG_RDP  = 2'd3;

    localparam logic [7:0] KEY_LO = 8'h56;
    localparam logic [7:0] KEY_HI = 8'hAE;
    localparam int NUM_KEYS = 2;
endpackage

// File: rtl/fwp_key_seq.sv
module fwp_key_seq
    import fwp_pkg::*;
#(
    parameter logic [7:0] FIRST_KEY  = 8'h56,
    parameter logic [7:0] SECOND_KEY = 8'hAE,
    parameter int         DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    input  logic              lock_wr,
    output logic              unlocked
);
    key_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_LOCKED: begin
                if (key_wr)
                    state_d = (key_val == DATA_W'(FIRST_KEY)) ? KS_HALF : KS_JAMMED;
            end
            KS_HALF: begin
                if (lock_wr)
                    state_d = KS_LOCKED;
                else if (key_wr)
                    state_d = (key_val == DATA_W'(SECOND_KEY)) ? KS_OPEN : KS_JAMMED;
            end
            KS_OPEN: begin
                if (lock_wr) state_d = KS_LOCKED;
            end
            KS_JAMMED: state_d = KS_JAMMED;
            default:   state_d = KS_JAMMED;
        endcase
    end

    always_comb begin
        unlocked = (state_q == KS_OPEN);
    end
endmodule

// File: rtl/fwp_region_dec.sv
module fwp_region_dec
    import fwp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PROG_BASE  = 'h8000,
    parameter int PROG_SIZE  = 'h8000,
    parameter int DATA_BASE  = 'h4000,
    parameter int DATA_SIZE  = 'h0400,
    parameter int OPT_BASE   = 'h4800,
    parameter int OPT_SIZE   = 'h0080,
    parameter int PAGE_SHIFT = 9,
    parameter int PAGE_CNT_W = 8
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [PAGE_CNT_W-1:0] boot_pages,
    output region_e               region,
    output logic                  in_boot
);
    localparam int XW = ADDR_W + 1;
    localparam logic [XW-1:0] P_LO  = XW'(PROG_BASE);
    localparam logic [XW-1:0] P_END = XW'(PROG_BASE + PROG_SIZE);
    localparam logic [XW-1:0] D_LO  = XW'(DATA_BASE);
    localparam logic [XW-1:0] D_END = XW'(DATA_BASE + DATA_SIZE);
    localparam logic [XW-1:0] O_LO  = XW'(OPT_BASE);
    localparam logic [XW-1:0] O_END = XW'(OPT_BASE + OPT_SIZE);

    logic [XW-1:0]     ax;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] page_idx;

    always_comb begin
        ax = {1'b0, addr};
        if (ax >= P_LO && ax < P_END)      region = RG_PROG;
        else if (ax >= D_LO && ax < D_END) region = RG_DATA;
        else if (ax >= O_LO && ax < O_END) region = RG_OPT;
        else                               region = RG_NONE;

        offset   = addr - ADDR_W'(PROG_BASE);
        page_idx = offset >> PAGE_SHIFT;
        in_boot  = (region == RG_PROG) && (page_idx < ADDR_W'(boot_pages));
    end
endmodule

// File: rtl/fwp_access_unit.sv
module fwp_access_unit
    import fwp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mem_req,
    input  logic    mem_wr,
    input  logic    dbg_mode,
    input  logic    rdprot,
    input  region_e region,
    input  logic    in_boot,
    input  logic    prog_open,
    input  logic    data_open,
    output logic    grant,
    output logic    deny,
    output logic    wr_error
);
    verdict_e state_q, state_d;
    logic     allow;
    logic     err_q;

    always_comb begin
        allow = 1'b1;
        if (dbg_mode && rdprot && (region == RG_PROG || region == RG_DATA)) begin
            allow = 1'b0;
        end else if (mem_wr) begin
            unique case (region)
                RG_PROG: allow = prog_open && !in_boot;
                RG_DATA: allow = data_open;
                RG_OPT:  allow = data_open;
                RG_NONE: allow = 1'b1;
                default: allow = 1'b0;
            endcase
        end
        if (!mem_req)   state_d = AV_IDLE;
        else if (allow) state_d = AV_GRANT;
        else            state_d = AV_DENY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AV_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_q | (mem_req && mem_wr && !allow);
        end
    end

    always_comb begin
        grant    = 1'b0;
        deny     = 1'b0;
        unique case (state_q)
            AV_IDLE:  ;
            AV_GRANT: grant = 1'b1;
            AV_DENY:  deny  = 1'b1;
            default:  deny  = 1'b1;
        endcase
        wr_error = err_q;
    end
endmodule

// File: rtl/fwp_erase_seq.sv
module fwp_erase_seq
    import fwp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rdp_wr,
    input  logic rdp_val,
    input  logic rdprot,
    output logic erase_all
);
    erase_state_e state_q, state_d;
    logic         attempt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ER_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        attempt = rdp_wr && (rdp_val != rdprot);
        unique case (state_q)
            ER_IDLE: state_d = attempt ? ER_FIRE : ER_IDLE;
            ER_FIRE: state_d = attempt ? ER_FIRE : ER_IDLE;
            default: state_d = ER_IDLE;
        endcase
    end

    always_comb begin
        erase_all = (state_q == ER_FIRE);
    end
endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
    import fwp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PROG_BASE  = 'h8000,
    parameter int PROG_SIZE  = 'h8000,
    parameter int DATA_BASE  = 'h4000,
    parameter int DATA_SIZE  = 'h0400,
    parameter int OPT_BASE   = 'h4800,
    parameter int OPT_SIZE   = 'h0080,
    parameter int PAGE_SHIFT = 9,
    parameter int PAGE_CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [1:0]            reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  mem_req,
    input  logic                  mem_wr,
    input  logic [ADDR_W-1:0]     mem_addr,
    input  logic                  dbg_mode,
    input  logic [PAGE_CNT_W-1:0] opt_boot_pages,
    input  logic                  opt_rdprot,
    output logic                  grant,
    output logic                  deny,
    output logic                  wr_error,
    output logic                  erase_all
);
    logic [NUM_KEYS-1:0] key_wr;
    logic [NUM_KEYS-1:0] lock_wr;
    logic [NUM_KEYS-1:0] open_vec;
    logic                rdp_wr;
    region_e             region;
    logic                in_boot;

    always_comb begin
        key_wr[0]  = reg_wr_en && (reg_addr == REG_PKEY);
        key_wr[1]  = reg_wr_en && (reg_addr == REG_DKEY);
        lock_wr[0] = reg_wr_en && (reg_addr == REG_LOCK) && reg_wdata[0];
        lock_wr[1] = reg_wr_en && (reg_addr == REG_LOCK) && reg_wdata[1];
        rdp_wr     = reg_wr_en && (reg_addr == REG_RDP);
    end

    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
        localparam logic [7:0] K_FIRST  = (g == 0) ? KEY_LO : KEY_HI;
        localparam logic [7:0] K_SECOND = (g == 0) ? KEY_HI : KEY_LO;
        fwp_key_seq #(
            .FIRST_KEY (K_FIRST),
            .SECOND_KEY(K_SECOND),
            .DATA_W    (DATA_W)
        ) u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .key_wr  (key_wr[g]),
            .key_val (reg_wdata),
            .lock_wr (lock_wr[g]),
            .unlocked(open_vec[g])
        );
    end

    fwp_region_dec #(
        .ADDR_W(ADDR_W), .PROG_BASE(PROG_BASE), .PROG_SIZE(PROG_SIZE),
        .DATA_BASE(DATA_BASE), .DATA_SIZE(DATA_SIZE),
        .OPT_BASE(OPT_BASE), .OPT_SIZE(OPT_SIZE),
        .PAGE_SHIFT(PAGE_SHIFT), .PAGE_CNT_W(PAGE_CNT_W)
    ) u_dec (
        .addr      (mem_addr),
        .boot_pages(opt_boot_pages),
        .region    (region),
        .in_boot   (in_boot)
    );

    fwp_access_unit u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_req  (mem_req),
        .mem_wr   (mem_wr),
        .dbg_mode (dbg_mode),
        .rdprot   (opt_rdprot),
        .region   (region),
        .in_boot  (in_boot),
        .prog_open(open_vec[0]),
        .data_open(open_vec[1]),
        .grant    (grant),
        .deny     (deny),
        .wr_error (wr_error)
    );

    fwp_erase_seq u_erase (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdp_wr   (rdp_wr),
        .rdp_val  (reg_wdata[0]),
        .rdprot   (opt_rdprot),
        .erase_all(erase_all)
    );
endmodule

// File: rtl/fwp_ctrl_chk.sv
module fwp_ctrl_chk #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PROG_BASE  = 'h8000,
    parameter int PROG_SIZE  = 'h8000,
    parameter int DATA_BASE  = 'h4000,
    parameter int DATA_SIZE  = 'h0400,
    parameter int OPT_BASE   = 'h4800,
    parameter int OPT_SIZE   = 'h0080,
    parameter int PAGE_SHIFT = 9,
    parameter int PAGE_CNT_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr_en,
    input logic [1:0]            reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic                  mem_req,
    input logic                  mem_wr,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic                  dbg_mode,
    input logic [PAGE_CNT_W-1:0] opt_boot_pages,
    input logic                  opt_rdprot,
    input logic                  grant,
    input logic                  deny,
    input logic                  wr_error,
    input logic                  erase_all
);
    logic [31:0] a32;
    logic        c_prog, c_data, c_boot, c_change;

    always_comb begin
        a32      = 32'(mem_addr);
        c_prog   = (a32 >= 32'(PROG_BASE)) && (a32 < 32'(PROG_BASE + PROG_SIZE));
        c_data   = (a32 >= 32'(DATA_BASE)) && (a32 < 32'(DATA_BASE + DATA_SIZE));
        c_boot   = c_prog && (((a32 - 32'(PROG_BASE)) >> PAGE_SHIFT) < 32'(opt_boot_pages));
        c_change = reg_wr_en && (reg_addr == 2'd3) && (reg_wdata[0] != opt_rdprot);
    end

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(grant && deny));
    a_r9_silent:    assert property (@(posedge clk) disable iff (!rst_n) !mem_req |=> !grant && !deny);
    a_r9_answer:    assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> grant || deny);
    a_r6_boot_deny: assert property (@(posedge clk) disable iff (!rst_n)
                        mem_req && mem_wr && c_boot |=> deny);
    a_r7_rdp_deny:  assert property (@(posedge clk) disable iff (!rst_n)
                        mem_req && dbg_mode && opt_rdprot && (c_prog || c_data) |=> deny);
    a_r8_fire:      assert property (@(posedge clk) disable iff (!rst_n) c_change |=> erase_all);
    a_r8_cause:     assert property (@(posedge clk) disable iff (!rst_n) erase_all |-> $past(c_change));
    a_r10_sticky:   assert property (@(posedge clk) disable iff (!rst_n) wr_error |=> wr_error);
    a_r10_cause:    assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_error) |-> deny);
endmodule

bind fwp_ctrl fwp_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_BASE(PROG_BASE), .PROG_SIZE(PROG_SIZE),
    .DATA_BASE(DATA_BASE), .DATA_SIZE(DATA_SIZE), .OPT_BASE(OPT_BASE), .OPT_SIZE(OPT_SIZE),
    .PAGE_SHIFT(PAGE_SHIFT), .PAGE_CNT_W(PAGE_CNT_W)
) u_chk (.*);

// File: tb/fwp_ctrl_bench.sv
module fwp_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        mem_req = 1'b0;
    logic        mem_wr = 1'b0;
    logic [15:0] mem_addr = '0;
    logic        dbg_mode = 1'b0;
    logic [7:0]  opt_boot_pages = '0;
    logic        opt_rdprot = 1'b0;
    logic        grant, deny, wr_error, erase_all;

    int n_checks = 0;
    int n_fail = 0;
    int p_st = 0;   // 0 locked, 1 half, 2 open, 3 jammed
    int d_st = 0;
    bit err_m = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;   // 10 time units = 100 MHz

    fwp_ctrl u_fwp_ctrl (
        .clk, .rst_n, .reg_wr_en, .reg_addr, .reg_wdata, .mem_req, .mem_wr, .mem_addr,
        .dbg_mode, .opt_boot_pages, .opt_rdprot, .grant, .deny, .wr_error, .erase_all
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit in_prog(input logic [15:0] a); return a >= 16'h8000; endfunction
    function automatic bit in_data(input logic [15:0] a); return a >= 16'h4000 && a <= 16'h43FF; endfunction
    function automatic bit in_opt(input logic [15:0] a);  return a >= 16'h4800 && a <= 16'h487F; endfunction
    function automatic bit in_boot(input logic [15:0] a);
        return in_prog(a) && (int'((a - 16'h8000) >> 9) < int'(opt_boot_pages));
    endfunction

    function automatic bit exp_ok(input logic [15:0] a, input bit wr, input bit dbg);
        if (dbg && opt_rdprot && (in_prog(a) || in_data(a))) return 1'b0;
        if (!wr) return 1'b1;
        if (in_prog(a)) return (p_st == 2) && !in_boot(a);
        if (in_data(a) || in_opt(a)) return d_st == 2;
        return 1'b1;
    endfunction

    function automatic int key_next(input int st, input logic [7:0] v, input logic [7:0] k1,
                                    input logic [7:0] k2);
        case (st)
            0: return (v == k1) ? 1 : 3;
            1: return (v == k2) ? 2 : 3;
            default: return st;
        endcase
    endfunction

    function automatic string reason(input bit mreq, input logic [15:0] a, input bit wr, input bit dbg);
        if (!mreq) return "R9";
        if (dbg && opt_rdprot && (in_prog(a) || in_data(a))) return "R7";
        if (wr && in_boot(a)) return "R6";
        if (wr && in_prog(a)) return "R2";
        if (wr && (in_data(a) || in_opt(a))) return "R3";
        return "R9";
    endfunction

    task automatic do_reset(input logic [7:0] pages, input bit rdp);
        @(negedge clk);
        rst_n = 1'b0; reg_wr_en = 1'b0; mem_req = 1'b0; dbg_mode = 1'b0;
        opt_boot_pages = pages; opt_rdprot = rdp;
        p_st = 0; d_st = 0; err_m = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "grant after reset", int'(grant), 0);
        check("R1", "deny after reset", int'(deny), 0);
        check("R1", "wr_error after reset", int'(wr_error), 0);
        check("R1", "erase_all after reset", int'(erase_all), 0);
    endtask

    task automatic step(input bit rw, input logic [1:0] ra, input logic [7:0] rd,
                        input bit mreq, input bit mwr, input logic [15:0] ma, input bit dbg,
                        input string tag);
        bit ok, eg, ed, ee;
        reg_wr_en = rw; reg_addr = ra; reg_wdata = rd;
        mem_req = mreq; mem_wr = mwr; mem_addr = ma; dbg_mode = dbg;
        ok = exp_ok(ma, mwr, dbg);
        eg = mreq && ok;
        ed = mreq && !ok;
        ee = rw && (ra == 2'd3) && (rd[0] != opt_rdprot);
        if (mreq && mwr && !ok) err_m = 1'b1;
        // R11: register effects applied after judging the request
        if (rw) begin
            case (ra)
                2'd0: p_st = key_next(p_st, rd, 8'h56, 8'hAE);
                2'd1: d_st = key_next(d_st, rd, 8'hAE, 8'h56);
                2'd2: begin
                    if (rd[0] && p_st != 3) p_st = 0;
                    if (rd[1] && d_st != 3) d_st = 0;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        reg_wr_en = 1'b0; mem_req = 1'b0;
        check(tag, "grant", int'(grant), int'(eg));
        check(tag, "deny", int'(deny), int'(ed));
        check("R8", "erase_all", int'(erase_all), int'(ee));
        check("R10", "wr_error", int'(wr_error), int'(err_m));
    endtask

    task automatic req(input bit wr, input logic [15:0] a, input bit dbg, input string tag);
        step(1'b0, 2'd0, 8'h00, 1'b1, wr, a, dbg, tag);
    endtask

    task automatic regw(input logic [1:0] ra, input logic [7:0] rd, input string tag);
        step(1'b1, ra, rd, 1'b0, 1'b0, 16'h0000, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1 reset state and default lock
        do_reset(8'd2, 1'b0);
        req(1'b0, 16'h9000, 1'b0, "R1");
        req(1'b1, 16'h9000, 1'b0, "R1");
        req(1'b1, 16'h4000, 1'b0, "R1");
        req(1'b1, 16'h4800, 1'b0, "R1");
        // R2 program unlock, R6 boot boundary
        regw(2'd0, 8'h56, "R2");
        regw(2'd0, 8'hAE, "R2");
        req(1'b1, 16'h8400, 1'b0, "R2");
        req(1'b1, 16'h83FF, 1'b0, "R6");
        // R11 lock write beside a program write, then R5 relock
        step(1'b1, 2'd2, 8'h01, 1'b1, 1'b1, 16'h9000, 1'b0, "R11");
        req(1'b1, 16'h9000, 1'b0, "R5");
        // R3 data unlock, second byte beside a data write (R11)
        regw(2'd1, 8'hAE, "R3");
        step(1'b1, 2'd1, 8'h56, 1'b1, 1'b1, 16'h4010, 1'b0, "R11");
        req(1'b1, 16'h4010, 1'b0, "R3");
        req(1'b1, 16'h487F, 1'b0, "R3");
        regw(2'd2, 8'h02, "R5");
        req(1'b1, 16'h4010, 1'b0, "R5");
        // R4 wrong byte jams program key
        regw(2'd0, 8'h11, "R4");
        regw(2'd0, 8'h56, "R4");
        regw(2'd0, 8'hAE, "R4");
        req(1'b1, 16'h9000, 1'b0, "R4");
        // R4 wrong order on data key
        do_reset(8'd0, 1'b0);
        regw(2'd1, 8'h56, "R4");
        regw(2'd1, 8'hAE, "R4");
        req(1'b1, 16'h4000, 1'b0, "R4");
        // R6 zero pages means no boot area
        do_reset(8'd0, 1'b0);
        regw(2'd0, 8'h56, "R6");
        regw(2'd0, 8'hAE, "R6");
        req(1'b1, 16'h8000, 1'b0, "R6");
        // R9 outside regions and idle
        req(1'b1, 16'h1000, 1'b0, "R9");
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 16'h9000, 1'b0, "R9");
        // R7 read-out protection with debug path; R10 reads leave error clear
        do_reset(8'd1, 1'b1);
        req(1'b0, 16'h9000, 1'b1, "R7");
        req(1'b0, 16'h4000, 1'b1, "R7");
        req(1'b0, 16'h4800, 1'b1, "R7");
        req(1'b0, 16'h9000, 1'b0, "R7");
        check("R10", "wr_error after denied reads", int'(wr_error), 0);
        req(1'b1, 16'h4000, 1'b1, "R7");
        req(1'b0, 16'h1000, 1'b0, "R10");
        // R8 erase on change attempt only
        regw(2'd3, 8'h00, "R8");
        regw(2'd3, 8'h01, "R8");
        regw(2'd3, 8'hFE, "R8");
        // random phase
        for (int seg = 0; seg < 8; seg++) begin
            do_reset(8'($urandom_range(0, 6)), 1'($urandom_range(0, 1)));
            for (int i = 0; i < 300; i++) begin
                bit rw, mreq, mwr, dbg;
                logic [1:0] ra;
                logic [7:0] rd;
                logic [15:0] ma;
                int k, r;
                k = $urandom_range(0, 9);
                rw = (k < 7);
                ra = (k < 3) ? 2'd0 : (k < 5) ? 2'd1 : (k < 6) ? 2'd2 : 2'd3;
                r = $urandom_range(0, 19);
                rd = (r < 9) ? 8'h56 : (r < 18) ? 8'hAE : 8'($urandom_range(0, 255));
                if (ra == 2'd2) rd = 8'($urandom_range(0, 3));
                if (ra == 2'd3) rd = 8'($urandom_range(0, 1));
                mreq = ($urandom_range(0, 9) < 7);
                mwr = 1'($urandom_range(0, 1));
                dbg = ($urandom_range(0, 3) == 0);
                r = $urandom_range(0, 9);
                ma = (r < 5) ? 16'(16'h8000 + $urandom_range(0, 16'h0FFF)) :
                     (r < 7) ? 16'(16'h4000 + $urandom_range(0, 16'h03FF)) :
                     (r < 9) ? 16'(16'h4800 + $urandom_range(0, 16'h007F)) : 16'h1234;
                step(rw, ra, rd, mreq, mwr, ma, dbg, reason(mreq, ma, mwr, dbg));
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule